// File: doc/BRIEF.md
# Fixed-Point Izhikevich Neuron Step Unit

This block holds the state of one spiking neuron and advances it by one discrete time step whenever its step enable is high. The neuron follows a scaled integer form of the Izhikevich model. The state is a signed membrane potential and a signed recovery variable, and a signed synaptic current drives the neuron from outside. The only true product is the square of the potential. The other scalings are arithmetic shifts.

Each enabled step computes the new potential and the new recovery value from the old ones in a single clock cycle. If the new potential reaches the firing threshold, the potential is set back to a fixed rest value, the recovery value receives a fixed bump, and a spike flag is raised for one cycle. A controller that owns many neurons pulses the step enable once per simulated time tick, presents that tick's current, and reads the spike flag in the cycle after it.

Top module: `izh_neuron`

## Requirements
- R1: While rst_n is low at a clock edge, the next state is v = -650, u = -163 (that is, -650 shifted right arithmetically by 2) and spike low.
- R2: On a step that does not fire, the new v is floor(v*v / 256) + 4*v + 1400 - u + I, using the old v and u. The result is clamped to the signed W-bit range.
- R3: On a step, the new u is u + ((v >>> 2) - u) >>> 6, using the old v and u. Every right shift is arithmetic, so it rounds toward minus infinity.
- R4: A step fires when the clamped new potential is at least 3000. The new v is then -650 instead. A potential of exactly 3000 fires and 2999 does not.
- R5: On a firing step, 80 is added to the new u from R3 and the sum is clamped to the signed W-bit range.
- R6: The potential sum is clamped at the signed W-bit limits instead of wrapping. A deeply negative v, whose square overflows the register range, therefore fires.
- R7: In a cycle with step_en low, v and u keep their values and spike is low in the next cycle, whatever the value of I.
- R8: spike is high for exactly the one cycle after an enabled step that fired. It is low after any enabled step that did not fire, including one directly after a firing step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance the neuron by one time step this cycle |
| cur_i | input | IW (16) | Signed synaptic input current for this step |
| spike_o | output | 1 | High for one cycle after a firing step |
| v_o | output | W (18) | Signed membrane potential |
| u_o | output | W (18) | Signed recovery variable |

## Verification
The assertions assume that step_en and cur_i are stable and known at every rising clock edge. They also assume that rst_n is held low for at least one edge before stepping starts. The threshold and hold properties further rely on the state never reaching 3000 except through a firing step. This is true only because the reset value and every written value lie below the threshold. The bench drives all inputs on falling edges and starts from a reset. It draws currents over the full signed input range, including the extremes, so that the potential sum swings from deep negative values to values that saturate. Directed steps from the reset state land exactly on the threshold and one below it.

// File: rtl/izh_pkg.sv
// Package: izh_pkg
// Purpose : shared constants of the scaled integer neuron model.
// Assumes : state width of at least 14 bits so every constant fits.
package izh_pkg;
    localparam int SQ_SHIFT  = 8;     // scaling of the squared potential
    localparam int LIN_SHIFT = 2;     // left shift applied to v in the potential sum
    localparam int A_SHIFT   = 6;     // recovery rate as a right shift
    localparam int B_SHIFT   = 2;     // recovery sensitivity as a right shift
    localparam int BIAS      = 1400;  // constant term of the potential sum
    localparam int THRESH    = 3000;  // firing threshold
    localparam int V_RESET   = -650;  // potential after a spike and after reset
    localparam int U_BUMP    = 80;    // recovery increment on a spike
    localparam int U_RESET   = V_RESET >>> B_SHIFT; // recovery value after reset
endpackage

// File: rtl/izh_potential.sv
// Module : izh_potential
// Purpose: combinational potential update v^2/256 + 4v + 1400 - u + I,
//          computed at double width and clamped to the signed W-bit range.
// Assumes: W >= 14; IW <= W. Pure combinational logic with no state.
module izh_potential #(
    parameter int W  = 18,
    parameter int IW = 16
) (
    input  logic signed [W-1:0]  v_i,
    input  logic signed [W-1:0]  u_i,
    input  logic signed [IW-1:0] cur_i,
    output logic signed [W-1:0]  v_sum_o
);
    import izh_pkg::*;

    localparam int SW = 2*W + 2;
    localparam logic signed [SW-1:0] MAXV = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [SW-1:0] MINV = ~MAXV;

    logic signed [2*W-1:0] sq;
    logic signed [SW-1:0]  sq_s;
    logic signed [SW-1:0]  lin_s;
    logic signed [SW-1:0]  acc;

    // Square, scale and sum all terms at a width that cannot overflow.
    always_comb begin
        sq    = v_i * v_i;
        sq_s  = SW'(sq >>> SQ_SHIFT);
        lin_s = SW'(v_i) <<< LIN_SHIFT;
        acc   = sq_s + lin_s + SW'(BIAS) - SW'(u_i) + SW'(cur_i);
    end

    // Clamp the wide sum to the register range.
    always_comb begin
        if (acc > MAXV)
            v_sum_o = MAXV[W-1:0];
        else if (acc < MINV)
            v_sum_o = MINV[W-1:0];
        else
            v_sum_o = acc[W-1:0];
    end
endmodule

// File: rtl/izh_recovery.sv
// Module : izh_recovery
// Purpose: combinational recovery update u + ((v>>>2) - u)>>>6 using only
//          arithmetic shifts and adds, clamped to the signed W-bit range.
// Assumes: inputs are the state of the previous step.
module izh_recovery #(
    parameter int W = 18
) (
    input  logic signed [W-1:0] v_i,
    input  logic signed [W-1:0] u_i,
    output logic signed [W-1:0] u_sum_o
);
    import izh_pkg::*;

    localparam int RW = W + 2;
    localparam logic signed [RW-1:0] MAXU = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [RW-1:0] MINU = ~MAXU;

    logic signed [RW-1:0] diff;
    logic signed [RW-1:0] delta;
    logic signed [RW-1:0] acc;

    // Difference between scaled potential and recovery, then the rate shift.
    always_comb begin
        diff  = RW'(v_i >>> B_SHIFT) - RW'(u_i);
        delta = diff >>> A_SHIFT;
        acc   = RW'(u_i) + delta;
    end

    // Clamp to the register range.
    always_comb begin
        if (acc > MAXU)
            u_sum_o = MAXU[W-1:0];
        else if (acc < MINU)
            u_sum_o = MINU[W-1:0];
        else
            u_sum_o = acc[W-1:0];
    end
endmodule

// File: rtl/izh_fire.sv
// Module : izh_fire
// Purpose: threshold compare and reset rule; on firing, the potential goes to
//          the rest value and the recovery value gets a clamped bump.
// Assumes: inputs are already clamped sums from the update stages.
module izh_fire #(
    parameter int W = 18
) (
    input  logic signed [W-1:0] v_sum_i,
    input  logic signed [W-1:0] u_sum_i,
    output logic                fire_o,
    output logic signed [W-1:0] v_new_o,
    output logic signed [W-1:0] u_new_o
);
    import izh_pkg::*;

    localparam logic signed [W-1:0] THR_W  = W'(THRESH);
    localparam logic signed [W-1:0] VRST_W = W'(V_RESET);
    localparam logic signed [W:0]   MAXB   = {2'b00, {(W-1){1'b1}}};

    logic signed [W:0] bumped;

    // Threshold decision.
    always_comb fire_o = (v_sum_i >= THR_W);

    // Recovery bump with clamping at the positive limit.
    always_comb begin
        bumped = (W+1)'(u_sum_i) + (W+1)'(U_BUMP);
        if (bumped > MAXB)
            bumped = MAXB;
    end

    // Select the post-step state.
    always_comb begin
        if (fire_o) begin
            v_new_o = VRST_W;
            u_new_o = bumped[W-1:0];
        end else begin
            v_new_o = v_sum_i;
            u_new_o = u_sum_i;
        end
    end
endmodule

// File: rtl/izh_neuron.sv
// Module : izh_neuron
// Purpose: one Izhikevich neuron. It holds v and u and advances them one time
//          step in every cycle with step_en high. The registered spike flag is
//          high in the cycle after a firing step.
// Assumes: synchronous active-low reset held for at least one edge before use;
//          W >= 14, IW <= W.
module izh_neuron #(
    parameter int W  = 18,
    parameter int IW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_en,
    input  logic signed [IW-1:0] cur_i,
    output logic                 spike_o,
    output logic signed [W-1:0]  v_o,
    output logic signed [W-1:0]  u_o
);
    import izh_pkg::*;

    localparam logic signed [W-1:0] VRST_W = W'(V_RESET);
    localparam logic signed [W-1:0] URST_W = W'(U_RESET);
    localparam logic signed [W-1:0] THR_W  = W'(THRESH);

    logic signed [W-1:0] v_q, u_q;
    logic                spike_q;
    logic signed [W-1:0] v_sum, u_sum, v_new, u_new;
    logic                fire;

    izh_potential #(.W(W), .IW(IW)) u_pot (
        .v_i    (v_q),
        .u_i    (u_q),
        .cur_i  (cur_i),
        .v_sum_o(v_sum)
    );

    izh_recovery #(.W(W)) u_rec (
        .v_i    (v_q),
        .u_i    (u_q),
        .u_sum_o(u_sum)
    );

    izh_fire #(.W(W)) u_fire (
        .v_sum_i(v_sum),
        .u_sum_i(u_sum),
        .fire_o (fire),
        .v_new_o(v_new),
        .u_new_o(u_new)
    );

    // State registers: load on reset, advance on an enabled step, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= VRST_W;
            u_q <= URST_W;
        end else if (step_en) begin
            v_q <= v_new;
            u_q <= u_new;
        end
    end

    // Spike flag: one cycle after an enabled step that fired.
    always_ff @(posedge clk) begin
        if (!rst_n)
            spike_q <= 1'b0;
        else
            spike_q <= step_en & fire;
    end

    assign v_o     = v_q;
    assign u_o     = u_q;
    assign spike_o = spike_q;

    // R1: reset loads the rest state.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (v_o == VRST_W && u_o == URST_W && !spike_o));

    // R4: a sum at or above threshold fires and reloads the rest potential.
    assert_fire_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && v_sum >= THR_W) |=> (spike_o && v_o == VRST_W));

    // R4: the stored potential never sits at or above threshold.
    assert_below_thresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
        v_o < THR_W);

    // R7: without a step the state holds and no spike follows.
    assert_hold_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(v_o) && $stable(u_o) && !spike_o));

    // R8: a non-firing step leaves the spike flag low.
    assert_no_false_spike_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && v_sum < THR_W) |=> !spike_o);
endmodule

// File: tb/tb_izh_neuron.sv
module tb_izh_neuron;
    localparam int W  = 18;
    localparam int IW = 16;
    localparam longint VMAX = (64'sd1 <<< (W-1)) - 1;
    localparam longint VMIN = -(64'sd1 <<< (W-1));

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 step_en = 1'b0;
    logic signed [IW-1:0] cur_i = '0;
    logic                 spike_o;
    logic signed [W-1:0]  v_o, u_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint mv, mu;
    bit     ms;

    always #2 clk = ~clk; // 250 MHz

    izh_neuron #(.W(W), .IW(IW)) dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .cur_i(cur_i),
        .spike_o(spike_o), .v_o(v_o), .u_o(u_o)
    );

    function automatic longint clampw(longint x);
        if (x > VMAX) return VMAX;
        if (x < VMIN) return VMIN;
        return x;
    endfunction

    // Reference step computed from the requirements (R2..R6).
    task automatic model_step(input longint cur, output longint nv,
                              output longint nu, output bit nf);
        longint vs, us;
        vs = clampw(((mv * mv) >>> 8) + (mv * 4) + 1400 - mu + cur);
        us = clampw(mu + (((mv >>> 2) - mu) >>> 6));
        nf = (vs >= 3000);
        nv = nf ? -650 : vs;
        nu = nf ? clampw(us + 80) : us;
    endtask

    task automatic check(input string req);
        checks++;
        if (longint'(v_o) != mv || longint'(u_o) != mu || spike_o != ms) begin
            errors++;
            $display("FAIL %s: v=%0d u=%0d spike=%0b expected v=%0d u=%0d spike=%0b",
                     req, v_o, u_o, spike_o, mv, mu, ms);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, compare.
    task automatic cycle(input bit en, input longint cur, input string req);
        longint nv, nu;
        bit nf;
        step_en = en;
        cur_i = IW'(cur);
        if (en) begin
            model_step(cur, nv, nu, nf);
            mv = nv; mu = nu; ms = nf;
        end else begin
            ms = 1'b0;
        end
        @(negedge clk);
        check(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step_en = 1'b0;
        @(negedge clk); @(negedge clk);
        mv = -650; mu = -163; ms = 1'b0;
        check("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20250611));
        @(negedge clk);
        do_reset();

        // R4: exactly on the threshold from the reset state (613 + 2387 = 3000).
        cycle(1'b1, 2387, "R4");
        if (spike_o !== 1'b1) begin errors++; $display("FAIL R4: spike=%0b expected 1", spike_o); end
        checks++;
        // R8: the next non-firing step drops the spike.
        cycle(1'b1, 0, "R8");
        do_reset();
        // R4/R2: one below the threshold.
        cycle(1'b1, 2386, "R4");
        if (v_o !== 18'sd2999) begin errors++; $display("FAIL R4: v=%0d expected 2999", v_o); end
        checks++;
        do_reset();
        // R3/R5: fire from rest with a large current.
        cycle(1'b1, 20000, "R5");
        cycle(1'b1, -100, "R3");
        // R7: hold with step low and large current.
        cycle(1'b0, 32767, "R7");
        cycle(1'b0, -32768, "R7");
        do_reset();
        // R6: drive deep negative, then the square saturates and fires.
        cycle(1'b1, -32768, "R2");
        cycle(1'b1, 0, "R6");
        if (spike_o !== 1'b1) begin errors++; $display("FAIL R6: spike=%0b expected 1", spike_o); end
        checks++;

        // Constrained random stimulus.
        for (int k = 0; k < 4000; k++) begin
            bit en;
            longint cur;
            int sel;
            en = ($urandom % 4) != 0;
            sel = $urandom % 8;
            if (sel == 0)      cur = 32767;
            else if (sel == 1) cur = -32768;
            else if (sel < 5)  cur = longint'($urandom % 4001) - 2000;
            else               cur = longint'($urandom % 65536) - 32768;
            if ((k % 500) == 499) do_reset();
            cycle(en, cur, en ? "R2" : "R7");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule